// File: doc/BRIEF.md
# Supervisor Trap-Value Register

This block holds the supervisor trap-value register and works out what goes into it when the core takes a trap. On the trap-valid strobe it reads the cause code and picks one of three kinds of value. For address-related causes it loads the faulting virtual address. For an illegal-instruction trap it loads the faulting encoding, when that capture option is built in. For every other cause it loads zero.

The captured encoding is cut down to the shortest of three lengths: the instruction's true length, the maximum instruction length, and the register width. It is then right-justified, and every bit above the kept length is cleared. The true length is supplied as a count of 16-bit parcels, and any bits above that length on the instruction input play no part.

On cycles without a trap, software may overwrite the register through a write port. If a trap and a software write arrive in the same cycle, the trap value is the one stored.

Top module: `trap_value_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the register output reads zero.
- R2: On a trap with cause code 2 (illegal instruction) and capture enabled, the register receives the low K bits of the instruction input and zero above them. K is the smallest of 16 times the parcel count, ILEN and the register width.
- R3: Instruction input bits at or above 16 times the parcel count never reach the register. For example, with a parcel count of 1, bits 16 and up of the result are zero.
- R4: On a trap with cause code 0, 1, 4, 5, 6, 7, 12, 13 or 15, the register receives the fault-address input.
- R5: On a trap with any other cause code, including codes above 15, the register receives zero.
- R6: When capture is disabled by parameter, a trap with cause code 2 loads zero.
- R7: In a cycle with neither a trap strobe nor a software write, the register keeps its value.
- R8: A software write with no trap in the same cycle loads the write data in the next cycle.
- R9: When a trap and a software write happen in the same cycle, the register takes the trap value and the write data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_fire | input | 1 | Strobe, high for one cycle when a trap is taken |
| trap_cause | input | CAUSE_W | Exception cause code |
| insn_bits | input | INSN_IN_W | Fetched instruction bits, with the first parcel in the low bits |
| insn_parcels | input | 3 | True instruction length as a count of 16-bit parcels |
| fault_addr | input | REG_W | Faulting virtual address for memory traps |
| csr_we | input | 1 | Software write enable |
| csr_wdata | input | REG_W | Software write data |
| tval_o | output | REG_W | Current register contents |

## Verification
A trap capture and a software write can both fall in the same cycle, and R9 decides which one wins. The bench first writes a known non-zero pattern into the register. It then raises the trap strobe and the write enable together, using a different write pattern. This is done once with an illegal-instruction cause and once with a cause that yields zero. The result is judged correct only if the register holds the trimmed encoding in the first case and zero in the second, with no trace of the write data in either.

// File: rtl/trap_value_pkg.sv
`timescale 1ns/1ps
package trap_value_pkg;

   typedef enum logic [1:0] {
      TV_KIND_ZERO = 2'd0,
      TV_KIND_ADDR = 2'd1,
      TV_KIND_INSN = 2'd2
   } tv_kind_e;

   localparam int PARCEL_BITS  = 16;
   localparam int CODE_ILLEGAL = 2;

   function automatic tv_kind_e tv_kind_of(input int unsigned code);
      tv_kind_e k;
      case (code)
         0, 1, 4, 5, 6, 7, 12, 13, 15: k = TV_KIND_ADDR;
         CODE_ILLEGAL:                 k = TV_KIND_INSN;
         default:                      k = TV_KIND_ZERO;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/tv_classify.sv
`timescale 1ns/1ps
module tv_classify
   import trap_value_pkg::*;
#(
   parameter int CAUSE_W = 6
) (
   input  logic [CAUSE_W-1:0] cause,
   output tv_kind_e           kind
);
   always_comb begin
      kind = tv_kind_of(32'(cause));
   end
endmodule

// File: rtl/tv_insn_trim.sv
`timescale 1ns/1ps
module tv_insn_trim
   import trap_value_pkg::*;
#(
   parameter int REG_W     = 64,
   parameter int ILEN      = 32,
   parameter int INSN_IN_W = 64
) (
   input  logic [INSN_IN_W-1:0] insn,
   input  logic [2:0]           parcels,
   output logic [REG_W-1:0]     trimmed
);
   localparam int CAP      = (ILEN < REG_W) ? ILEN : REG_W;
   localparam int KEEP_W   = 8;
   localparam int SHIFT_W  = $clog2(PARCEL_BITS);

   logic [KEEP_W-1:0] parcel_len;
   logic [KEEP_W-1:0] keep;

   always_comb begin
      parcel_len = KEEP_W'({parcels, {SHIFT_W{1'b0}}});
      keep       = parcel_len;
      if (keep > KEEP_W'(CAP)) begin
         keep = KEEP_W'(CAP);
      end
   end

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i < INSN_IN_W) begin : g_src
         assign trimmed[i] = insn[i] & (KEEP_W'(i) < keep);
      end else begin : g_pad
         assign trimmed[i] = 1'b0;
      end
   end
endmodule

// File: rtl/tv_hold_reg.sv
`timescale 1ns/1ps
module tv_hold_reg #(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_trap,
   input  logic [REG_W-1:0] trap_val,
   input  logic             sw_we,
   input  logic [REG_W-1:0] sw_wdata,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load_trap) begin
         q <= trap_val;
      end else if (sw_we) begin
         q <= sw_wdata;
      end
   end
endmodule

// File: rtl/trap_value_reg.sv
`timescale 1ns/1ps
module trap_value_reg
   import trap_value_pkg::*;
#(
   parameter int REG_W      = 64,
   parameter int ILEN       = 32,
   parameter int INSN_IN_W  = 64,
   parameter int CAUSE_W    = 6,
   parameter bit CAPTURE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trap_fire,
   input  logic [CAUSE_W-1:0]   trap_cause,
   input  logic [INSN_IN_W-1:0] insn_bits,
   input  logic [2:0]           insn_parcels,
   input  logic [REG_W-1:0]     fault_addr,
   input  logic                 csr_we,
   input  logic [REG_W-1:0]     csr_wdata,
   output logic [REG_W-1:0]     tval_o
);
   if (!(REG_W == 32 || REG_W == 64)) begin : g_bad_reg_w
      $error("REG_W must be 32 or 64");
   end
   if ((ILEN % PARCEL_BITS) != 0 || ILEN < PARCEL_BITS || ILEN > 64) begin : g_bad_ilen
      $error("ILEN must be a multiple of 16 between 16 and 64");
   end
   if (INSN_IN_W < ILEN || INSN_IN_W > 128) begin : g_bad_in_w
      $error("INSN_IN_W must cover ILEN and stay at or below 128");
   end
   if (CAUSE_W < 4 || CAUSE_W > 32) begin : g_bad_cause_w
      $error("CAUSE_W must lie between 4 and 32");
   end

   tv_kind_e         kind;
   logic [REG_W-1:0] insn_val;
   logic [REG_W-1:0] trap_val;

   tv_classify #(.CAUSE_W(CAUSE_W)) u_class (
      .cause (trap_cause),
      .kind  (kind)
   );

   if (CAPTURE_EN) begin : g_capture
      tv_insn_trim #(
         .REG_W     (REG_W),
         .ILEN      (ILEN),
         .INSN_IN_W (INSN_IN_W)
      ) u_trim (
         .insn    (insn_bits),
         .parcels (insn_parcels),
         .trimmed (insn_val)
      );
   end else begin : g_no_capture
      assign insn_val = '0;
   end

   always_comb begin
      case (kind)
         TV_KIND_ADDR: trap_val = fault_addr;
         TV_KIND_INSN: trap_val = insn_val;
         default:      trap_val = '0;
      endcase
   end

   tv_hold_reg #(.REG_W(REG_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_trap (trap_fire),
      .trap_val  (trap_val),
      .sw_we     (csr_we),
      .sw_wdata  (csr_wdata),
      .q         (tval_o)
   );
endmodule

// File: rtl/tv_checker.sv
`timescale 1ns/1ps
module tv_checker #(
   parameter int REG_W   = 64,
   parameter int ILEN    = 32,
   parameter int CAUSE_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trap_fire,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [2:0]         insn_parcels,
   input logic [REG_W-1:0]   fault_addr,
   input logic               csr_we,
   input logic [REG_W-1:0]   csr_wdata,
   input logic [REG_W-1:0]   tval
);
   localparam int CAPB = (ILEN < REG_W) ? ILEN : REG_W;
   localparam logic [REG_W-1:0] LOW_MASK =
      (CAPB >= REG_W) ? '1 : ((REG_W'(1) << CAPB) - REG_W'(1));
   localparam logic [REG_W-1:0] PARCEL_MASK = REG_W'(16'hFFFF);

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (tval == '0)); // R1

   AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire && trap_cause == CAUSE_W'(2) |=> ((tval & ~LOW_MASK) == '0)); // R2

   AST_ONE_PARCEL: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire && trap_cause == CAUSE_W'(2) && insn_parcels == 3'd1
      |=> ((tval & ~PARCEL_MASK) == '0)); // R3

   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire && trap_cause == CAUSE_W'(13) |=> (tval == $past(fault_addr))); // R4

   AST_ZERO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire && trap_cause == CAUSE_W'(3) |=> (tval == '0)); // R5

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_fire && !csr_we |=> $stable(tval)); // R7

   AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_fire && csr_we |=> (tval == $past(csr_wdata))); // R8

   AST_TRAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire && csr_we && trap_cause == CAUSE_W'(3) |=> (tval == '0)); // R9
endmodule

bind trap_value_reg tv_checker #(
   .REG_W   (REG_W),
   .ILEN    (ILEN),
   .CAUSE_W (CAUSE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trap_fire    (trap_fire),
   .trap_cause   (trap_cause),
   .insn_parcels (insn_parcels),
   .fault_addr   (fault_addr),
   .csr_we       (csr_we),
   .csr_wdata    (csr_wdata),
   .tval         (tval_o)
);

// File: tb/sim_trap_value_reg.sv
`timescale 1ns/1ps
module sim_trap_value_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_fire = 1'b0;
   logic [5:0]  trap_cause = '0;
   logic [63:0] insn_bits = '0;
   logic [2:0]  insn_parcels = 3'd1;
   logic [63:0] fault_addr = '0;
   logic        csr_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] t0, t2;
   logic [31:0] t1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // u0: 64-bit register, ILEN 32; u1: 32-bit register, ILEN 64; u2: capture off
   trap_value_reg #(.REG_W(64), .ILEN(32), .CAPTURE_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .trap_fire(trap_fire), .trap_cause(trap_cause),
      .insn_bits(insn_bits), .insn_parcels(insn_parcels), .fault_addr(fault_addr),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .tval_o(t0));
   trap_value_reg #(.REG_W(32), .ILEN(64), .CAPTURE_EN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .trap_fire(trap_fire), .trap_cause(trap_cause),
      .insn_bits(insn_bits), .insn_parcels(insn_parcels), .fault_addr(fault_addr[31:0]),
      .csr_we(csr_we), .csr_wdata(csr_wdata[31:0]), .tval_o(t1));
   trap_value_reg #(.REG_W(64), .ILEN(32), .CAPTURE_EN(1'b0)) u2 (
      .clk(clk), .rst_n(rst_n), .trap_fire(trap_fire), .trap_cause(trap_cause),
      .insn_bits(insn_bits), .insn_parcels(insn_parcels), .fault_addr(fault_addr),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .tval_o(t2));

   typedef struct {
      logic [63:0] e0;
      logic [63:0] e1;
      logic [63:0] e2;
      string       tag;
   } exp_t;
   exp_t sb[$];
   logic [63:0] m0 = '0, m1 = '0, m2 = '0;

   function automatic logic [63:0] model(int regw, int ilen, bit cap, int code,
                                         logic [63:0] insn, int parcels, logic [63:0] addr);
      logic [63:0] r = '0;
      int k;
      case (code)
         0, 1, 4, 5, 6, 7, 12, 13, 15: r = addr;
         2: if (cap) begin
               k = parcels * 16;
               if (k > ilen) k = ilen;
               if (k > regw) k = regw;
               for (int i = 0; i < k; i++) r[i] = insn[i];
            end
         default: r = '0;
      endcase
      if (regw == 32) r[63:32] = '0;
      return r;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(bit trap, int code, logic [63:0] insn, int parcels,
                       logic [63:0] addr, bit we, logic [63:0] wdata, string tag);
      exp_t e;
      @(negedge clk);
      trap_fire    = trap;
      trap_cause   = 6'(code);
      insn_bits    = insn;
      insn_parcels = 3'(parcels);
      fault_addr   = addr;
      csr_we       = we;
      csr_wdata    = wdata;
      if (trap) begin
         m0 = model(64, 32, 1'b1, code, insn, parcels, addr);
         m1 = model(32, 64, 1'b1, code, insn, parcels, addr);
         m2 = model(64, 32, 1'b0, code, insn, parcels, addr);
      end else if (we) begin
         m0 = wdata;
         m1 = {32'h0, wdata[31:0]};
         m2 = wdata;
      end
      e.e0 = m0; e.e1 = m1; e.e2 = m2; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: one expected entry per driven cycle, sampled 1 ns after the edge
   always begin
      exp_t e;
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
         e = sb.pop_front();
         check({e.tag, " u0"}, t0, e.e0);
         check({e.tag, " u1"}, {32'h0, t1}, e.e1);
         check({e.tag, " u2"}, t2, e.e2);
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [63:0] INSN_A = 64'hDEAD_BEEF_CAFE_8073;
   localparam logic [63:0] INSN_B = 64'h1357_9BDF_2468_ACE3;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset u0", t0, 64'h0);
      check("R1 in reset u1", {32'h0, t1}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release u0", t0, 64'h0);
      check("R1 after release u2", t2, 64'h0);

      step(1, 2, INSN_A, 1, 64'h0, 0, 64'h0, "R2 R3 R6 one parcel");
      step(1, 2, INSN_A, 2, 64'h0, 0, 64'h0, "R2 R6 two parcels");
      step(1, 2, INSN_B, 3, 64'h0, 0, 64'h0, "R2 three parcels");
      step(1, 2, INSN_B, 4, 64'h0, 0, 64'h0, "R2 four parcels width limits");
      step(0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 4, 64'h5, 0, 64'h9, "R7 idle hold");
      step(0, 0, 64'h0, 1, 64'h0, 1, 64'hA5A5_5A5A_0F0F_F0F0, "R8 software write");
      step(0, 0, 64'h0, 1, 64'h0, 0, 64'h0, "R7 hold after write");
      step(1, 13, 64'h0, 1, 64'h8000_0000_1234_5678, 0, 64'h0, "R4 page fault");
      step(1, 0, 64'h0, 1, 64'h0000_7FFF_0000_0002, 0, 64'h0, "R4 misaligned fetch");
      step(1, 6, 64'h0, 1, 64'hFEDC_BA98_7654_3210, 0, 64'h0, "R4 store misaligned");
      step(0, 0, 64'h0, 1, 64'h0, 1, 64'h1111_2222_3333_4444, "R8 preload");
      step(1, 3, INSN_A, 2, 64'hABCD, 0, 64'h0, "R5 cause 3");
      step(0, 0, 64'h0, 1, 64'h0, 1, 64'h5555_6666_7777_8888, "R8 preload");
      step(1, 11, INSN_A, 2, 64'hABCD, 0, 64'h0, "R5 cause 11");
      step(0, 0, 64'h0, 1, 64'h0, 1, 64'h9999_AAAA_BBBB_CCCC, "R8 preload");
      step(1, 40, INSN_A, 2, 64'hABCD, 0, 64'h0, "R5 cause 40");
      step(0, 0, 64'h0, 1, 64'h0, 1, 64'h0123_4567_89AB_CDEF, "R8 preload");
      step(1, 2, INSN_B, 2, 64'h0, 1, 64'hFFFF_0000_FFFF_0000, "R9 illegal beats write");
      step(0, 0, 64'h0, 1, 64'h0, 1, 64'h0F0F_0F0F_0F0F_0F0F, "R8 preload");
      step(1, 3, 64'h0, 1, 64'h0, 1, 64'hEEEE_EEEE_EEEE_EEEE, "R9 zero cause beats write");
      step(0, 0, 64'h0, 1, 64'h0, 0, 64'h0, "R7 final hold");

      while (sb.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule